// File: doc/BRIEF.md
# Parity-Protected Composite 8-bit Substitution Box

This block is a purely combinational 8-bit to 8-bit substitution box. It is built from two stages of 4-bit table lookups with a linear mixing layer between them. The input byte splits into two nibbles. The high nibble goes to sub-box 0 and the low nibble to sub-box 1. The two results are cross-mixed using doubling in GF(2^4) modulo z^4 + z + 1. The mixed nibbles then pass through sub-boxes 2 and 3, whose outputs form the high and low nibbles of the result.

Every sub-box table entry carries a fifth bit. That bit is the XOR of the parity of the entry's address and the parity of its 4-bit data. From this bit and the parity of the value arriving at the sub-box, the block predicts the parity of each sub-box output. A mismatch with the actual parity raises that sub-box's error flag and substitutes the fault-free table value.

The second-stage parity inputs are predicted through the mixing layer from first-stage predictions, rather than recomputed from the mixed data. A fault in the linear layer therefore also shows up as a flag. A test control can XOR a mask into the data field of one chosen sub-box table, which exercises the detection and correction paths.

Top module: `sbox_guard`

## Requirements
- R1: With fault injection off, the output is the composition y = {SS2(u0), SS3(u1)}, where:
  - t0 = SS0(x[7:4]) and t1 = SS1(x[3:0]);
  - u0 = t0 ^ 2·t1 and u1 = 2·t0 ^ t1;
  - 2·a = {a[2:0],0} ^ (a[3] ? 4'h3 : 0).
  - The tables are SS0 = e6ca872fb14059d3, SS1 = 640d2ba39cef8751, SS2 = b85ea64cf72310d9 and SS3 = a26d345e0789bfc1, each listed from index 0 to index 15 in hex.
- R2: With fault injection off, every bit of `boxErr` is 0 and `anyErr` is 0 for all 256 inputs.
- R3: While `faultEn` is 0, the values of `faultSel` and `faultMask` have no effect on `sOut`, `boxErr` or `anyErr`.
- R4: With `faultEn` = 1, a mask of odd weight in sub-box `faultSel` raises `boxErr[faultSel]`, where bit i belongs to SSi. The other bits stay 0. This holds for every input byte.
- R5: When a sub-box flag is raised, that sub-box's fault-free entry is used, so `sOut` equals the fault-free result of R1.
- R6: A mask of even weight is not detected, so all flags stay 0. The corrupted nibble then propagates: `sOut` equals R1 with the selected table's data XORed with the mask.
- R7: `anyErr` is 1 exactly when at least one bit of `boxErr` is 1.
- R8: Second-stage parity predictions come through the mixing layer, using parity(2·a) = parity(a) ^ a[3]. A corrected first-stage fault therefore raises no second-stage flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sIn | input | 8 | Byte to substitute; bits 7:4 feed SS0 and bits 3:0 feed SS1 |
| faultEn | input | 1 | Enables table corruption for test |
| faultSel | input | 2 | Index of the sub-box whose table is corrupted |
| faultMask | input | 4 | XOR mask applied to the selected table's data field |
| sOut | output | 8 | Substituted (corrected) byte |
| boxErr | output | 4 | Per-sub-box parity mismatch flags, bit i for SSi |
| anyErr | output | 1 | OR of all sub-box flags |

## Verification
The bench builds the block with its default nibble width of 4. With that width the 8-bit input space has only 256 values, so the sweep can be exhaustive. Every input is tested fault-free, then again with a nonzero mask and `faultEn` held low. Every input is also tested under each of the 15 nonzero masks in each of the four sub-boxes. This covers all single-bit faults, all odd-weight faults that must be corrected, and all even-weight faults that must pass through undetected. The expected bytes and flags come from the tables and the GF(2^4) doubling rule as computed in the bench.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int NIB = 4;
  localparam int NUM_BOX = 4;
  localparam int BYTE_W = 2 * NIB;

  typedef struct packed {
    logic [NUM_BOX-1:0] inject;
    logic [NIB-1:0]     mask;
  } sboxStrobe_t;

  function automatic logic [NIB-1:0] ssClean(input int boxId, input logic [NIB-1:0] a);
    logic [63:0] tbl;
    case (boxId)
      0:       tbl = 64'he6ca872fb14059d3;
      1:       tbl = 64'h640d2ba39cef8751;
      2:       tbl = 64'hb85ea64cf72310d9;
      default: tbl = 64'ha26d345e0789bfc1;
    endcase
    return tbl[63 - 4*a -: 4];
  endfunction

  function automatic logic [NIB:0] romEntry(input int boxId, input logic [NIB-1:0] a);
    logic [NIB-1:0] d;
    d = ssClean(boxId, a);
    return {(^a) ^ (^d), d};
  endfunction

  function automatic logic [NIB-1:0] mulTwo(input logic [NIB-1:0] a);
    return {a[2:0], 1'b0} ^ (a[3] ? 4'h3 : 4'h0);
  endfunction

endpackage

// File: rtl/sbox_sub.sv
module sbox_sub
  import sbox_pkg::*;
#(
  parameter int BOX_ID = 0
) (
  input  logic [NIB-1:0] addr,
  input  logic           inParity,
  input  logic           inject,
  input  logic [NIB-1:0] mask,
  output logic [NIB-1:0] dataOut,
  output logic           predPar,
  output logic           err
);

  logic [NIB:0]   entry;
  logic [NIB-1:0] rawData;

  always_comb begin
    entry   = romEntry(BOX_ID, addr);
    rawData = entry[NIB-1:0] ^ (inject ? mask : '0);
    predPar = inParity ^ entry[NIB];
    err     = predPar ^ (^rawData);
    dataOut = err ? ssClean(BOX_ID, addr) : rawData;
  end

  always_comb begin
    if (!$isunknown({addr, inParity, inject, mask})) begin
      if (!inject && inParity == ^addr)
        AST_CLEAN_NO_FLAG: assert (!err); // R2
      if (inject && $countones(mask) == 1 && inParity == ^addr)
        AST_SINGLE_BIT_DETECT: assert (err); // R4
      if (inParity == ^addr)
        AST_OUT_PARITY: assert ((^dataOut) == predPar || !err); // R5
    end
  end

endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0]  sIn,
  input  sboxStrobe_t        strobe,
  output logic [BYTE_W-1:0]  sOut,
  output logic [NUM_BOX-1:0] boxErr
);

  logic [NIB-1:0] t [2];
  logic [NIB-1:0] u [2];
  logic [NIB-1:0] v [2];
  logic [1:0] pt;
  logic [1:0] pu;
  logic [1:0] pv;
  logic [NIB-1:0] nibIn [2];

  assign nibIn[0] = sIn[BYTE_W-1:NIB];
  assign nibIn[1] = sIn[NIB-1:0];

  for (genvar g = 0; g < 2; g++) begin : gStage1
    sbox_sub #(.BOX_ID(g)) i_sub (
      .addr    (nibIn[g]),
      .inParity(^nibIn[g]),
      .inject  (strobe.inject[g]),
      .mask    (strobe.mask),
      .dataOut (t[g]),
      .predPar (pt[g]),
      .err     (boxErr[g])
    );
  end

  always_comb begin
    u[0]  = t[0] ^ mulTwo(t[1]);
    u[1]  = mulTwo(t[0]) ^ t[1];
    pu[0] = pt[0] ^ pt[1] ^ t[1][NIB-1];
    pu[1] = pt[0] ^ t[0][NIB-1] ^ pt[1];
  end

  always_comb begin
    if (!$isunknown({t[0], t[1], pt}) && pt[0] == ^t[0] && pt[1] == ^t[1])
      AST_MIX_PARITY: assert (pu[0] == ^u[0] && pu[1] == ^u[1]); // R8
  end

  for (genvar g = 0; g < 2; g++) begin : gStage2
    sbox_sub #(.BOX_ID(g + 2)) i_sub (
      .addr    (u[g]),
      .inParity(pu[g]),
      .inject  (strobe.inject[g+2]),
      .mask    (strobe.mask),
      .dataOut (v[g]),
      .predPar (pv[g]),
      .err     (boxErr[g+2])
    );
  end

  assign sOut = {v[0], v[1]};

endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic               faultEn,
  input  logic [1:0]         faultSel,
  input  logic [NIB-1:0]     faultMask,
  input  logic [NUM_BOX-1:0] boxErr,
  output sboxStrobe_t        strobe,
  output logic               anyErr
);

  always_comb begin
    strobe.inject = '0;
    if (faultEn) strobe.inject[faultSel] = 1'b1;
    strobe.mask = faultMask;
    anyErr = |boxErr;
  end

  always_comb begin
    if (!$isunknown({faultEn, faultSel, boxErr})) begin
      AST_ONEHOT_FLAGS: assert ($onehot0(boxErr)); // R4
      if (!faultEn)
        AST_FLAG_NEEDS_FAULT: assert (boxErr == '0); // R3
      if (boxErr != '0)
        AST_FLAG_IN_SELECTED: assert (boxErr[faultSel]); // R4
    end
  end

endmodule

// File: rtl/sbox_guard.sv
module sbox_guard
  import sbox_pkg::*;
(
  input  logic [7:0] sIn,
  input  logic       faultEn,
  input  logic [1:0] faultSel,
  input  logic [3:0] faultMask,
  output logic [7:0] sOut,
  output logic [3:0] boxErr,
  output logic       anyErr
);

  sboxStrobe_t strobe;

  sbox_ctrl i_ctrl (
    .faultEn  (faultEn),
    .faultSel (faultSel),
    .faultMask(faultMask),
    .boxErr   (boxErr),
    .strobe   (strobe),
    .anyErr   (anyErr)
  );

  sbox_datapath i_dp (
    .sIn   (sIn),
    .strobe(strobe),
    .sOut  (sOut),
    .boxErr(boxErr)
  );

endmodule

// File: tb/test_sbox_guard.sv
module test_sbox_guard;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] sIn = 8'h00;
  logic       faultEn = 1'b0;
  logic [1:0] faultSel = 2'd0;
  logic [3:0] faultMask = 4'h0;
  logic [7:0] sOut;
  logic [3:0] boxErr;
  logic       anyErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  sbox_guard i_sbox_guard (
    .sIn(sIn), .faultEn(faultEn), .faultSel(faultSel), .faultMask(faultMask),
    .sOut(sOut), .boxErr(boxErr), .anyErr(anyErr)
  );

  function automatic logic [3:0] refTbl(input int k, input logic [3:0] a);
    logic [3:0] s0 [16] = '{4'he,4'h6,4'hc,4'ha,4'h8,4'h7,4'h2,4'hf,4'hb,4'h1,4'h4,4'h0,4'h5,4'h9,4'hd,4'h3};
    logic [3:0] s1 [16] = '{4'h6,4'h4,4'h0,4'hd,4'h2,4'hb,4'ha,4'h3,4'h9,4'hc,4'he,4'hf,4'h8,4'h7,4'h5,4'h1};
    logic [3:0] s2 [16] = '{4'hb,4'h8,4'h5,4'he,4'ha,4'h6,4'h4,4'hc,4'hf,4'h7,4'h2,4'h3,4'h1,4'h0,4'hd,4'h9};
    logic [3:0] s3 [16] = '{4'ha,4'h2,4'h6,4'hd,4'h3,4'h4,4'h5,4'he,4'h0,4'h7,4'h8,4'h9,4'hb,4'hf,4'hc,4'h1};
    case (k)
      0: return s0[a];
      1: return s1[a];
      2: return s2[a];
      default: return s3[a];
    endcase
  endfunction

  function automatic logic [3:0] dbl(input logic [3:0] a);
    logic [4:0] p;
    p = {a, 1'b0};
    if (p[4]) p = p ^ 5'b10011;
    return p[3:0];
  endfunction

  // Look up sub-box k with mask m applied; odd weight means detected and corrected.
  function automatic logic [3:0] look(input int k, input logic [3:0] a, input int fk,
                                      input logic [3:0] m);
    if (k == fk && ($countones(m) % 2) == 0) return refTbl(k, a) ^ m;
    return refTbl(k, a);
  endfunction

  function automatic logic [7:0] model(input logic [7:0] x, input int fk, input logic [3:0] m);
    logic [3:0] t0, t1;
    t0 = look(0, x[7:4], fk, m);
    t1 = look(1, x[3:0], fk, m);
    return {look(2, t0 ^ dbl(t1), fk, m), look(3, dbl(t0) ^ t1, fk, m)};
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s x=%h sel=%0d mask=%h en=%0b: got %h expected %h",
               req, sIn, faultSel, faultMask, faultEn, act, exp);
    end
  endtask

  initial begin
    #200_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0] expFlags;
    @(negedge clk);
    check("R2 reset-state", {sOut, boxErr, anyErr}, {model(8'h00, -1, 4'h0), 4'h0, 1'b0});
    // R1 R2: fault-free sweep
    for (int x = 0; x < 256; x++) begin
      sIn = 8'(x);
      #2;
      check("R1", {sOut, 5'b0}, {model(8'(x), -1, 4'h0), 5'b0});
      check("R2", {8'h00, boxErr, anyErr}, 13'h0);
    end
    // R3: disabled injection ignores select and mask
    faultSel = 2'd3;
    faultMask = 4'h1;
    for (int x = 0; x < 256; x++) begin
      sIn = 8'(x);
      faultSel = 2'(x);
      faultMask = 4'(x) | 4'h1;
      #2;
      check("R3", {sOut, boxErr, anyErr}, {model(8'(x), -1, 4'h0), 5'b0});
    end
    // R4 R5 R6 R7 R8: every box, every nonzero mask, every input
    faultEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      for (int m = 1; m < 16; m++) begin
        faultSel = 2'(k);
        faultMask = 4'(m);
        expFlags = (($countones(4'(m)) % 2) == 1) ? 4'(1 << k) : 4'h0;
        for (int x = 0; x < 256; x++) begin
          sIn = 8'(x);
          #2;
          if (expFlags != 0) begin
            check("R4 R8 flags", {8'h00, boxErr, 1'b0}, {8'h00, expFlags, 1'b0});
            check("R5 corrected", {sOut, 5'b0}, {model(8'(x), -1, 4'h0), 5'b0});
          end else begin
            check("R6 undetected", {sOut, boxErr, 1'b0}, {model(8'(x), k, 4'(m)), 5'b0});
          end
          check("R7 anyErr", {12'h0, anyErr}, {12'h0, (expFlags != 0)});
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule